// File: doc/BRIEF.md
# Byte-Latching Serial Configuration Register

This block is a write-only serial slave that receives a 16-bit configuration word over three wires: an active-low select, a serial clock and a serial data line. While the select is low, each rising edge of the serial clock shifts in one data bit, most significant bit first. The word is not loaded as one unit at the end of the frame. Each time a complete group of eight bits has arrived, that group is written straight into its own byte of the holding register. A host can therefore change only the upper byte by sending a short eight-bit frame.

The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and rising edges of the serial clock are detected in the system domain. The serial clock must run at no more than a quarter of the system clock rate. The holding register drives three decoded fields: a 4-bit octave, a 10-bit DAC code and a 2-bit output configuration. A one-cycle update strobe, together with a flag naming the byte just written, marks every commit.

Top module: `spi_cfg_reg`

## Requirements
- R1: While the select is low, data is sampled on rising edges of the serial clock, first bit into word bit 15. A 16-bit frame loads the whole word.
- R2: The fields decode as octave = word[15:12], DAC code = word[11:2] and configuration = word[1:0].
- R3: On the eighth rising edge of a frame, those eight bits are written into word[15:8]. An eight-bit-only frame changes the upper byte and leaves word[7:0] unchanged.
- R4: On the sixteenth rising edge, bits nine through sixteen of the frame are written into word[7:0].
- R5: When the select rises in the middle of a byte, the partial bits are discarded, and bytes already committed in that frame keep their values.
- R6: After reset, the word is zero and the update strobe is low.
- R7: Serial clock edges while the select is high change neither the word nor the strobe.
- R8: After the sixteenth edge of a frame, bit counting wraps. The next eight bits go to word[15:8] again.
- R9: Each commit raises upd_o for exactly one system cycle. upd_hi_o is 1 when word[15:8] was written and 0 when word[7:0] was written.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous, at most clk/4 |
| ser_dat | input | 1 | Serial data |
| oct_o | output | 4 | Octave field |
| dac_o | output | 10 | DAC code field |
| cfg_o | output | 2 | Output configuration field |
| upd_o | output | 1 | One-cycle strobe on each byte commit |
| upd_hi_o | output | 1 | Byte index of the commit (1 = upper) |

## Verification
The assertions check these properties on every cycle:
- The word changes only in a cycle that carries the update strobe.
- The strobe lasts a single cycle.
- An upper-byte commit leaves the lower byte alone, and a lower-byte commit leaves the upper byte alone.
- No commit occurs after the select has been high for several cycles.

Only the bench scenarios can show the actual bit order and the field placement. The same holds for the effect of aborted, short and over-long frames, because those depend on which serial bits the host sent.

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg #(
  parameter int BYTE_W  = 8,
  parameter int OCT_W   = 4,
  parameter int CFG_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_sel_n,
  input  logic                          ser_clk,
  input  logic                          ser_dat,
  output logic [OCT_W-1:0]              oct_o,
  output logic [2*BYTE_W-OCT_W-CFG_W-1:0] dac_o,
  output logic [CFG_W-1:0]              cfg_o,
  output logic                          upd_o,
  output logic                          upd_hi_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int DAC_W  = WORD_W - OCT_W - CFG_W;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int CNT_W  = BIT_W + 1;

  logic [1:0] sel_s, clk_s, dat_s;
  logic       clk_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_s <= '1;
      clk_s <= '0;
      dat_s <= '0;
      clk_d <= 1'b0;
    end else begin
      sel_s <= {sel_s[0], ser_sel_n};
      clk_s <= {clk_s[0], ser_clk};
      dat_s <= {dat_s[0], ser_dat};
      clk_d <= clk_s[1];
    end
  end

  wire active   = !sel_s[1];
  wire rise     = clk_s[1] && !clk_d;
  wire take     = active && rise;
  wire byte_end = (cnt_q[BIT_W-1:0] == BIT_W'(BYTE_W-1));
  wire to_hi    = !cnt_q[CNT_W-1];
  wire [BYTE_W-1:0] new_byte = {sh_q, dat_s[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      word_q   <= '0;
      upd_o    <= 1'b0;
      upd_hi_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (!active) begin
        cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= new_byte[BYTE_W-2:0];
        if (byte_end) begin
          upd_o    <= 1'b1;
          upd_hi_o <= to_hi;
          if (to_hi) word_q[WORD_W-1:BYTE_W] <= new_byte;
          else       word_q[BYTE_W-1:0]      <= new_byte;
        end
      end
    end
  end

  assign oct_o = word_q[WORD_W-1 -: OCT_W];
  assign dac_o = word_q[CFG_W +: DAC_W];
  assign cfg_o = word_q[CFG_W-1:0];
endmodule

module spi_cfg_reg_chk #(
  parameter int BYTE_W = 8,
  parameter int OCT_W  = 4,
  parameter int CFG_W  = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ser_sel_n,
  input logic [OCT_W-1:0]              oct_o,
  input logic [2*BYTE_W-OCT_W-CFG_W-1:0] dac_o,
  input logic [CFG_W-1:0]              cfg_o,
  input logic                          upd_o,
  input logic                          upd_hi_o
);
  localparam int WORD_W = 2 * BYTE_W;
  wire [WORD_W-1:0] word = {oct_o, dac_o, cfg_o};

  // R9
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R9
  word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(word));

  // R3
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && upd_hi_o) |-> $stable(word[BYTE_W-1:0]));

  // R4
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !upd_hi_o) |-> $stable(word[WORD_W-1:BYTE_W]));

  // R7
  idle_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_n && $past(ser_sel_n) && $past(ser_sel_n, 2) &&
     $past(ser_sel_n, 3) && $past(ser_sel_n, 4)) |-> !upd_o);
endmodule

bind spi_cfg_reg spi_cfg_reg_chk #(.BYTE_W(BYTE_W), .OCT_W(OCT_W), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n),
  .oct_o(oct_o), .dac_o(dac_o), .cfg_o(cfg_o),
  .upd_o(upd_o), .upd_hi_o(upd_hi_o)
);

// File: tb/spi_cfg_reg_tb_top.sv
module spi_cfg_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdat = 1'b0;
  logic [3:0] oct;
  logic [9:0] dac;
  logic [1:0] cfg;
  logic upd, upd_hi;

  int checks = 0, errors = 0;
  int n_upd = 0, n_hi = 0, n_multi = 0;
  logic upd_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_reg dut_i (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sck), .ser_dat(sdat),
    .oct_o(oct), .dac_o(dac), .cfg_o(cfg), .upd_o(upd), .upd_hi_o(upd_hi)
  );

  always @(negedge clk) begin
    if (upd) begin
      n_upd++;
      if (upd_hi) n_hi++;
      if (upd_prev) n_multi++;
    end
    upd_prev = upd;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [15:0] exp);
    @(negedge clk);
    check(req, {28'd0, oct}, {28'd0, exp[15:12]});
    check(req, {22'd0, dac}, {22'd0, exp[11:2]});
    check(req, {30'd0, cfg}, {30'd0, exp[1:0]});
  endtask

  task automatic send(input logic [31:0] bits, input int n, input logic drop_sel);
    if (drop_sel) sel_n = 1'b0;
    repeat (HALF_SCK) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      sck  = 1'b0;
      repeat (HALF_SCK) @(negedge clk);
      sck = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF_SCK) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    // R6
    check("R6", {31'd0, upd}, 32'd0);
    check_word("R6", 16'h0000);
  endtask

  task automatic t_full(input logic [15:0] w);
    int u0 = n_upd, h0 = n_hi;
    send({16'd0, w}, 16, 1'b1);
    // R1 R2 R4
    check_word("R1_R2", w);
    // R9
    check("R9", n_upd - u0, 2);
    check("R9", n_hi - h0, 1);
  endtask

  task automatic t_upper_only;
    int u0 = n_upd, h0 = n_hi;
    send(32'h5A, 8, 1'b1);
    // R3
    check_word("R3", 16'h5AD7);
    check("R3", n_upd - u0, 1);
    check("R9", n_hi - h0, 1);
  endtask

  task automatic t_abort;
    int u0 = n_upd;
    send({19'd0, 13'h1234 >> 0}, 13, 1'b1);
    // R5: first 8 of 13 bits of 0x1234 (13 bits: 1_0010_0011_0100) -> 0x91
    check_word("R5", 16'h91D7);
    check("R5", n_upd - u0, 1);
  endtask

  task automatic t_wrap;
    int u0 = n_upd, h0 = n_hi;
    send(32'hA1B2C3, 24, 1'b1);
    // R8
    check_word("R8", 16'hC3B2);
    check("R8", n_upd - u0, 3);
    check("R8", n_hi - h0, 2);
  endtask

  task automatic t_idle;
    int u0 = n_upd;
    send(32'hFFFF, 16, 1'b0);
    // R7
    check_word("R7", 16'hC3B2);
    check("R7", n_upd - u0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full(16'hB2D7);
    t_upper_only();
    t_abort();
    t_wrap();
    t_idle();
    t_full(16'hFFFF);
    t_full(16'h0001);
    // R9
    check("R9", n_multi, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule